// File: doc/BRIEF.md
# Receive Descriptor Ring Consumer

This block is the host half of a receive ring. It keeps a small ring of descriptor status words in a local register array. When a poll request arrives, it watches the status word at the current ring position. It waits for the device side to hand that entry back by setting the ownership bit. Once the entry comes back, the block decides whether the frame may be passed upward and reports the payload length without the trailing CRC. It then re-arms the entry with the receive buffer size and steps to the next ring position.

If the entry is not handed back within a configured number of attempts, the wait is abandoned. In that case the ring position stays where it was. Every completed poll, whether it returned a frame or timed out, ends with a one-cycle strobe that tells the receiver to restart. A separate write port and read port let the device side, or a test, fill and inspect any descriptor status word. Moving frame data and bus mastering are not part of this block.

Top module: `rxr_ring_consumer`

## Requirements
- R1: After reset the ring position is 0, every descriptor status word reads 1536 (ownership bit 31 clear), and busy, done, deliver, timeout and restart are all 0, with length 0.
- R2: A poll request taken while idle raises busy on the next cycle. Each following cycle checks bit 31 of the current entry. When bit 31 is already set, done pulses on the second clock edge after the request edge.
- R3: deliver pulses together with done only when the status word ANDed with the mask of bits 30, 27 and 22 equals exactly bit 27 (more-fragments clear, packet-OK set, too-long clear).
- R4: When deliver is high, length equals status bits 11:0 minus 4, modulo 4096. When done pulses without deliver, length is 0.
- R5: The entry that completes a poll is rewritten to 1536 on the completing edge, whether or not it was delivered. If an external write hits the same entry on that edge, the rewrite wins.
- R6: Each done advances the ring position by one, wrapping from 3 to 0.
- R7: If bit 31 never appears, timeout pulses after exactly TIMEOUT_POLLS checks, which is TIMEOUT_POLLS+1 edges after the request edge. Done does not pulse, the ring position does not change and the entry is not rewritten.
- R8: restart pulses for exactly one cycle with each done or timeout, and is never high while busy.
- R9: A poll request that arrives while a wait is in progress is ignored. It neither extends nor repeats the wait.
- R10: done and timeout are single-cycle pulses and are never high together.
- R11: An entry whose ownership bit is set during a wait is picked up on the edge after the write lands, so done follows the external write by two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | External write enable for a descriptor status word |
| desc_widx | input | 2 | Entry selected by the external write |
| desc_wdata | input | 32 | Status word to write |
| desc_ridx | input | 2 | Entry selected for read-back |
| desc_rdata | output | 32 | Status word of the selected entry (combinational) |
| poll_req | input | 1 | Start a wait on the current entry |
| poll_busy | output | 1 | A wait is in progress |
| rx_done | output | 1 | Entry handed back and consumed (pulse) |
| rx_deliver | output | 1 | Consumed frame is acceptable (pulse with done) |
| rx_len | output | 12 | Payload length without CRC, valid with deliver |
| rx_timeout | output | 1 | Wait abandoned (pulse) |
| rx_restart | output | 1 | Receiver restart strobe at the end of every poll |
| ring_idx | output | 2 | Current ring position |

## Verification
On every cycle the assertions check four things. Done and timeout never coincide, and a delivery always comes with a done. The ring position steps by one with wrap on a done and holds on a timeout. The consumed entry holds the buffer size after the rewrite. The attempt counter stays below its limit, and the restart strobe never overlaps busy. Some behaviour is only visible in the bench's scenarios: the exact acceptance pattern over the three status bits, the length underflow wrap, the precise timeout latency, the ignored second request, the late hand-back during a wait, and the rewrite beating a colliding external write.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int STAT_W   = 32;
    localparam int LEN_W    = 12;
    localparam int CRC_B    = 4;

    localparam int OWN_POS  = 31;
    localparam int FRAG_POS = 30;
    localparam int GOOD_POS = 27;
    localparam int LONG_POS = 22;

    typedef logic [STAT_W-1:0] stat_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_WAIT = 1'b1
    } eng_state_e;

    typedef struct packed {
        logic             accept;
        logic [LEN_W-1:0] len;
    } verdict_t;

    function automatic logic is_host_owned(stat_t s);
        return s[OWN_POS];
    endfunction

    function automatic verdict_t judge_frame(stat_t s);
        verdict_t v;
        v.accept = s[GOOD_POS] & ~s[FRAG_POS] & ~s[LONG_POS];
        v.len    = v.accept ? (s[LEN_W-1:0] - LEN_W'(CRC_B)) : '0;
        return v;
    endfunction

endpackage

// File: rtl/rxr_desc_store.sv
module rxr_desc_store
    import rxr_pkg::*;
#(
    parameter int ENTRIES   = 4,
    parameter int BUF_BYTES = 1536,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_we,
    input  logic [IDX_W-1:0] ext_idx,
    input  stat_t            ext_data,
    input  logic             rearm_we,
    input  logic [IDX_W-1:0] rearm_idx,
    input  logic [IDX_W-1:0] host_idx,
    output stat_t            host_data,
    input  logic [IDX_W-1:0] eng_idx,
    output stat_t            eng_data
);

    localparam stat_t ARMED = stat_t'(BUF_BYTES);

    stat_t ent [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[e] <= ARMED;
            end else if (rearm_we && rearm_idx == IDX_W'(e)) begin
                ent[e] <= ARMED;
            end else if (ext_we && ext_idx == IDX_W'(e)) begin
                ent[e] <= ext_data;
            end
        end
    end

    assign host_data = ent[host_idx];
    assign eng_data  = ent[eng_idx];

    // R5: a consumed entry holds the buffer size after the edge
    a_r5_rearm_lands: assert property (@(posedge clk) disable iff (rst)
        rearm_we |=> ent[$past(rearm_idx)] == ARMED);

endmodule

// File: rtl/rxr_poll_engine.sv
module rxr_poll_engine
    import rxr_pkg::*;
#(
    parameter int ENTRIES       = 4,
    parameter int TIMEOUT_POLLS = 1000000,
    localparam int IDX_W        = $clog2(ENTRIES),
    localparam int CNT_W        = $clog2(TIMEOUT_POLLS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             poll_req,
    input  stat_t            cur_stat,
    output logic [IDX_W-1:0] cur_idx,
    output logic             rearm_we,
    output logic             busy,
    output logic             done,
    output logic             deliver,
    output logic [LEN_W-1:0] len,
    output logic             timeout,
    output logic             restart
);

    localparam logic [CNT_W-1:0] LAST_TRY = CNT_W'(TIMEOUT_POLLS - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    eng_state_e       state;
    logic [CNT_W-1:0] tries;
    logic             seen;
    verdict_t         verdict;
    logic [IDX_W-1:0] next_idx;

    always_comb begin
        seen     = (state == ENG_WAIT) && is_host_owned(cur_stat);
        verdict  = judge_frame(cur_stat);
        next_idx = (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;
    end

    assign rearm_we = seen;
    assign busy     = (state == ENG_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ENG_IDLE;
            tries   <= '0;
            cur_idx <= '0;
            done    <= 1'b0;
            deliver <= 1'b0;
            len     <= '0;
            timeout <= 1'b0;
            restart <= 1'b0;
        end else begin
            done    <= 1'b0;
            deliver <= 1'b0;
            len     <= '0;
            timeout <= 1'b0;
            restart <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (poll_req) begin
                        state <= ENG_WAIT;
                        tries <= '0;
                    end
                end
                ENG_WAIT: begin
                    if (seen) begin
                        done    <= 1'b1;
                        deliver <= verdict.accept;
                        len     <= verdict.len;
                        restart <= 1'b1;
                        cur_idx <= next_idx;
                        state   <= ENG_IDLE;
                    end else if (tries == LAST_TRY) begin
                        timeout <= 1'b1;
                        restart <= 1'b1;
                        state   <= ENG_IDLE;
                    end else begin
                        tries <= tries + 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R10: completion pulses are exclusive
    a_r10_done_xor_timeout: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout));

    // R3: acceptance only with a consumed entry
    a_r3_deliver_needs_done: assert property (@(posedge clk) disable iff (rst)
        deliver |-> done);

    // R6: ring position steps with wrap on completion
    a_r6_index_step: assert property (@(posedge clk) disable iff (rst)
        done |-> cur_idx == (($past(cur_idx) == LAST_IDX) ? '0 : $past(cur_idx) + 1'b1));

    // R7: ring position holds on a timeout
    a_r7_index_hold: assert property (@(posedge clk) disable iff (rst)
        timeout |-> cur_idx == $past(cur_idx));

    // R7: attempt counter stays inside its window
    a_r7_tries_bound: assert property (@(posedge clk) disable iff (rst)
        tries <= LAST_TRY);

    // R8: restart strobe only when the wait is over
    a_r8_restart_idle: assert property (@(posedge clk) disable iff (rst)
        restart |-> !busy);

endmodule

// File: rtl/rxr_ring_consumer.sv
module rxr_ring_consumer
    import rxr_pkg::*;
#(
    parameter int ENTRIES       = 4,
    parameter int BUF_BYTES     = 1536,
    parameter int TIMEOUT_POLLS = 1000000,
    localparam int IDX_W        = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             desc_we,
    input  logic [IDX_W-1:0] desc_widx,
    input  logic [31:0]      desc_wdata,
    input  logic [IDX_W-1:0] desc_ridx,
    output logic [31:0]      desc_rdata,
    input  logic             poll_req,
    output logic             poll_busy,
    output logic             rx_done,
    output logic             rx_deliver,
    output logic [11:0]      rx_len,
    output logic             rx_timeout,
    output logic             rx_restart,
    output logic [IDX_W-1:0] ring_idx
);

    stat_t            eng_stat;
    logic             rearm_we;
    logic [IDX_W-1:0] cur_idx;

    rxr_desc_store #(
        .ENTRIES  (ENTRIES),
        .BUF_BYTES(BUF_BYTES)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .ext_we   (desc_we),
        .ext_idx  (desc_widx),
        .ext_data (desc_wdata),
        .rearm_we (rearm_we),
        .rearm_idx(cur_idx),
        .host_idx (desc_ridx),
        .host_data(desc_rdata),
        .eng_idx  (cur_idx),
        .eng_data (eng_stat)
    );

    rxr_poll_engine #(
        .ENTRIES      (ENTRIES),
        .TIMEOUT_POLLS(TIMEOUT_POLLS)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .poll_req(poll_req),
        .cur_stat(eng_stat),
        .cur_idx (cur_idx),
        .rearm_we(rearm_we),
        .busy    (poll_busy),
        .done    (rx_done),
        .deliver (rx_deliver),
        .len     (rx_len),
        .timeout (rx_timeout),
        .restart (rx_restart)
    );

    assign ring_idx = cur_idx;

endmodule

// File: tb/sim_rxr_ring_consumer.sv
module sim_rxr_ring_consumer;

    localparam int CLK_PERIOD = 10;
    localparam int TO         = 16;
    localparam int ARMED      = 1536;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_we = 1'b0;
    logic [1:0]  desc_widx = '0;
    logic [31:0] desc_wdata = '0;
    logic [1:0]  desc_ridx = '0;
    logic [31:0] desc_rdata;
    logic        poll_req = 1'b0;
    logic        poll_busy, rx_done, rx_deliver, rx_timeout, rx_restart;
    logic [11:0] rx_len;
    logic [1:0]  ring_idx;

    int checks = 0;
    int fails  = 0;
    int unsigned seed_init = $urandom(32'd2024);

    logic [31:0] mdl [4];
    int          midx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxr_ring_consumer #(.TIMEOUT_POLLS(TO)) u0 (
        .clk(clk), .rst(rst),
        .desc_we(desc_we), .desc_widx(desc_widx), .desc_wdata(desc_wdata),
        .desc_ridx(desc_ridx), .desc_rdata(desc_rdata),
        .poll_req(poll_req), .poll_busy(poll_busy),
        .rx_done(rx_done), .rx_deliver(rx_deliver), .rx_len(rx_len),
        .rx_timeout(rx_timeout), .rx_restart(rx_restart), .ring_idx(ring_idx)
    );

    function automatic logic exp_accept(logic [31:0] s);
        return (s & 32'h4840_0000) == 32'h0800_0000;
    endfunction

    function automatic logic [11:0] exp_len(logic [31:0] s);
        return exp_accept(s) ? (s[11:0] - 12'd4) : 12'd0;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        desc_we = 1'b1; desc_widx = 2'(idx); desc_wdata = d;
        @(negedge clk);
        desc_we = 1'b0;
        mdl[idx] = d;
    endtask

    task automatic host_read(input int idx, output logic [31:0] d);
        desc_ridx = 2'(idx);
        #1;
        d = desc_rdata;
    endtask

    task automatic run_poll(input int inj_k, input logic [31:0] inj_d, input int rereq_k,
                            output int k_end, output logic g_done, output logic g_del,
                            output logic [11:0] g_len, output logic g_to, output int n_rs);
        int  k;
        logic fin;
        k = 0; fin = 1'b0; g_done = 0; g_del = 0; g_len = 0; g_to = 0; n_rs = 0;
        @(negedge clk);
        poll_req = 1'b1;
        @(negedge clk);
        poll_req = 1'b0;
        k = 1;
        chk(poll_busy === 1'b1, "R2", "busy after request", 32'(poll_busy), 1);
        while (!fin && k <= TO + 8) begin
            if (rx_restart) n_rs++;
            if (rx_done || rx_timeout) begin
                fin = 1'b1; g_done = rx_done; g_del = rx_deliver;
                g_len = rx_len; g_to = rx_timeout;
            end
            desc_we  = !fin && (k == inj_k);
            desc_widx = ring_idx;
            desc_wdata = inj_d;
            poll_req = !fin && (k == rereq_k);
            if (!fin) begin
                @(negedge clk);
                k++;
            end
        end
        desc_we = 1'b0; poll_req = 1'b0;
        k_end = k;
        repeat (2) begin
            @(negedge clk);
            if (rx_restart) n_rs++;
        end
    endtask

    task automatic frame_case(input logic [31:0] s, input string tag);
        int k; logic d, dl, to; logic [11:0] ln; int rs; logic [31:0] rb;
        int old;
        old = midx;
        host_write(old, s);
        run_poll(-1, 0, -1, k, d, dl, ln, to, rs);
        chk(d === 1'b1 && to === 1'b0, "R2", {tag, " done"}, 32'(d), 1);
        chk(k == 2, "R2", {tag, " latency"}, 32'(k), 2);
        chk(dl === exp_accept(s), "R3", {tag, " deliver"}, 32'(dl), 32'(exp_accept(s)));
        chk(ln === exp_len(s), "R4", {tag, " length"}, 32'(ln), 32'(exp_len(s)));
        chk(rs == 1, "R8", {tag, " restart count"}, 32'(rs), 1);
        midx = (midx + 1) % 4;
        chk(ring_idx === 2'(midx), "R6", {tag, " index"}, 32'(ring_idx), 32'(midx));
        mdl[old] = ARMED;
        host_read(old, rb);
        chk(rb === 32'(ARMED), "R5", {tag, " rearm"}, rb, ARMED);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int k; logic d, dl, to; logic [11:0] ln; int rs; logic [31:0] rb;
        int old;
        for (int i = 0; i < 4; i++) mdl[i] = ARMED;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ring_idx === 2'd0, "R1", "index", 32'(ring_idx), 0);
        chk({poll_busy, rx_done, rx_deliver, rx_timeout, rx_restart} === 5'b0,
            "R1", "outputs", 32'({poll_busy, rx_done, rx_deliver, rx_timeout, rx_restart}), 0);
        chk(rx_len === 12'd0, "R1", "length", 32'(rx_len), 0);
        for (int i = 0; i < 4; i++) begin
            host_read(i, rb);
            chk(rb === 32'(ARMED), "R1", "entry armed", rb, ARMED);
        end

        // R7 timeout with R9 ignored second request
        run_poll(-1, 0, 3, k, d, dl, ln, to, rs);
        chk(to === 1'b1 && d === 1'b0, "R7", "timeout flag", 32'({d, to}), 1);
        chk(k == TO + 1, "R7", "timeout latency", 32'(k), TO + 1);
        chk(ring_idx === 2'(midx), "R7", "index held", 32'(ring_idx), 32'(midx));
        host_read(midx, rb);
        chk(rb === 32'(ARMED), "R7", "entry untouched", rb, ARMED);
        chk(rs == 1, "R8", "single restart", 32'(rs), 1);
        chk(poll_busy === 1'b0, "R9", "no second wait", 32'(poll_busy), 0);
        chk(!(d && to), "R10", "exclusive pulses", 32'({d, to}), 32'h1);

        // directed acceptance patterns
        frame_case(32'h8800_0040, "good");
        frame_case(32'hC800_0040, "more+ok");
        frame_case(32'h8840_0100, "long+ok");
        frame_case(32'h8000_0080, "no ok");
        frame_case(32'h8800_0002, "underflow");
        frame_case(32'h8800_0FFF, "max len");

        // R11 late hand-back during a wait
        old = midx;
        run_poll(5, 32'h8800_0050, -1, k, d, dl, ln, to, rs);
        chk(d === 1'b1 && k == 7, "R11", "late pickup latency", 32'(k), 7);
        chk(ln === 12'h04C, "R11", "late length", 32'(ln), 32'h4C);
        midx = (midx + 1) % 4;
        chk(ring_idx === 2'(midx), "R6", "late index", 32'(ring_idx), 32'(midx));

        // R5 collision: rewrite beats external write on same edge
        old = midx;
        host_write(old, 32'h8800_0020);
        run_poll(1, 32'h0000_0ABC, -1, k, d, dl, ln, to, rs);
        chk(d === 1'b1 && dl === 1'b1 && k == 2, "R5", "collision done", 32'(k), 2);
        host_read(old, rb);
        chk(rb === 32'(ARMED), "R5", "rewrite wins", rb, ARMED);
        midx = (midx + 1) % 4;

        // random frames, wrapping the ring many times
        for (int i = 0; i < 40; i++) begin
            logic [31:0] s;
            s = $urandom;
            s[31] = 1'b1;
            s[30] = ($urandom % 4) == 0;
            s[27] = ($urandom % 4) != 0;
            s[22] = ($urandom % 4) == 0;
            frame_case(s, "random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule